// File: doc/BRIEF.md
# Lock-Protected Configuration Register Controller

This block owns one 8-bit control/status register that a host reaches over a two-wire serial target bus. A separate bit-level front end turns the wire activity into byte-level events: a start (or repeated start), a stop, a received byte tagged with its position in the transaction, and a request for read data. The block answers each received byte with an acknowledge decision one cycle later and answers each read request with the register image.

Changing the six persistent bits takes three transactions. The first sets a write-enable latch, the second sets a register-write-enable latch as well, and the third carries the new image. The third write takes effect only when the stop condition arrives. A busy period follows, modelled by a cycle counter. At the end of it the persistent bits take the new values and the register-write-enable latch drops. A write-protect input blocks updates to the persistent bits. A read is a random read: a dummy write of the register address, a repeated start, then one byte.

Top module: `cfgLockReg`

## Requirements
- R1: A byte in position 0 is acknowledged only when its upper seven bits equal the device address (default 7'b1010010). Bit 0 set means a read and bit 0 clear means a write. Any other address gets no acknowledge.
- R2: In a write, the byte in position 1 must be FFh to select the register. Any other value gets no acknowledge, and the data byte that follows also gets no acknowledge and has no effect.
- R3: A single data byte of 02h sets the write-enable latch (register bit 1) at the stop condition. The busy flag does not rise.
- R4: A data byte of 06h sets both latches (bits 2 and 1) only if the write-enable latch is already set. Otherwise it changes nothing.
- R5: With both latches set, a data byte with bit 2 clear starts a busy period at the stop condition. When the period ends, bits 7, 6, 5, 4, 3 and 0 take the byte's values and bit 2 clears, while bit 1 stays set.
- R6: With both latches set, a data byte with bit 2 set leaves the persistent bits unchanged, keeps both latches set and starts no busy period.
- R7: The sequence 02h, 06h, 02h clears all six persistent bits.
- R8: A second data byte in one transaction gets no acknowledge and cancels the pending write.
- R9: While write-protect is high, a final data write leaves the register unchanged and starts no busy period.
- R10: While busy, a write address byte gets no acknowledge. A read address is still acknowledged and returns the current image.
- R11: A read transaction returns exactly one byte. A further read request in the same transaction produces no read strobe. Reads work after the latches are set and before the final write.
- R12: After reset the register image is 00h and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wpIn | input | 1 | Write protect for the persistent bits, active high |
| evStart | input | 1 | Start or repeated start seen, one-cycle pulse |
| evStop | input | 1 | Stop seen, one-cycle pulse |
| rxValid | input | 1 | Received byte valid, one-cycle pulse |
| rxPos | input | 2 | Byte position: 0 address, 1 register address, 2 first data, 3 later data |
| rxByte | input | 8 | Received byte |
| rdReq | input | 1 | Front end requests a read byte |
| ackStrobe | output | 1 | Acknowledge decision valid |
| ackOk | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rdStrobe | output | 1 | Read data valid |
| rdData | output | 8 | Read byte |
| regImage | output | 8 | Current register image |
| busy | output | 1 | Persistent update in progress |

## Verification
The bench builds the block with a busy period of 20 cycles instead of the millisecond-scale default. This lets it issue write and read attempts inside the busy window and then wait for the update to finish. Acknowledge decisions and read bytes go through an expected-value queue in the order the bench issues them. The register image and the busy flag are checked directly after each stop, so the bench can tell an immediate latch update apart from a deferred commit.

// File: rtl/cfgLockPkg.sv
package cfgLockPkg;
  localparam int BYTE_W = 8;
  localparam int POS_W  = 2;
  // positions of the persistent bits inside the image
  localparam logic [BYTE_W-1:0] NV_MASK = 8'b1111_1001;
  localparam int WEL_BIT  = 1;
  localparam int RWEL_BIT = 2;

  typedef enum logic [POS_W-1:0] {
    POS_DEV  = 2'd0,
    POS_REG  = 2'd1,
    POS_DATA = 2'd2,
    POS_MORE = 2'd3
  } posT;

  typedef struct packed {
    logic              setWel;
    logic              setRwel;
    logic              commit;
    logic [BYTE_W-1:0] data;
  } strobeT;
endpackage

// File: rtl/cfgLockCtrl.sv
module cfgLockCtrl
  import cfgLockPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010010,
  parameter logic [7:0] REG_ADDR = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              rxValid,
  input  logic [POS_W-1:0]  rxPos,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rdReq,
  input  logic              welIn,
  input  logic              rwelIn,
  input  logic              busyIn,
  input  logic [BYTE_W-1:0] imageIn,
  output logic              ackStrobe,
  output logic              ackOk,
  output logic              rdStrobe,
  output logic [BYTE_W-1:0] rdData,
  output strobeT            strb
);
  logic writeSel, regSel, pendValid, readActive;
  logic [BYTE_W-1:0] pendByte;
  logic ackNext;
  logic devMatch;

  assign devMatch = (rxByte[7:1] == DEV_ADDR);

  always_comb begin
    ackNext = 1'b0;
    unique case (posT'(rxPos))
      POS_DEV:  ackNext = devMatch && (rxByte[0] || !busyIn);
      POS_REG:  ackNext = writeSel && (rxByte == REG_ADDR);
      POS_DATA: ackNext = regSel;
      POS_MORE: ackNext = 1'b0;
      default:  ackNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeSel   <= 1'b0;
      regSel     <= 1'b0;
      pendValid  <= 1'b0;
      pendByte   <= '0;
      readActive <= 1'b0;
      ackStrobe  <= 1'b0;
      ackOk      <= 1'b0;
      rdStrobe   <= 1'b0;
      rdData     <= '0;
    end else begin
      ackStrobe <= rxValid;
      ackOk     <= rxValid && ackNext;
      rdStrobe  <= rdReq && readActive;
      if (rdReq && readActive) begin
        rdData     <= imageIn;
        readActive <= 1'b0;
      end
      if (evStart || evStop) begin
        writeSel   <= 1'b0;
        regSel     <= 1'b0;
        pendValid  <= 1'b0;
        readActive <= 1'b0;
      end else if (rxValid) begin
        unique case (posT'(rxPos))
          POS_DEV: begin
            writeSel   <= devMatch && !rxByte[0] && !busyIn;
            readActive <= devMatch && rxByte[0];
          end
          POS_REG:  regSel <= writeSel && (rxByte == REG_ADDR);
          POS_DATA: if (regSel) begin
            pendValid <= 1'b1;
            pendByte  <= rxByte;
          end
          POS_MORE: pendValid <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // decode of the pending byte at the stop condition
  always_comb begin
    strb = '0;
    strb.data = pendByte;
    if (evStop && pendValid) begin
      if (welIn && rwelIn) begin
        strb.commit = !pendByte[RWEL_BIT];
      end else if (pendByte == 8'h02) begin
        strb.setWel = 1'b1;
      end else if (pendByte == 8'h06 && welIn) begin
        strb.setWel  = 1'b1;
        strb.setRwel = 1'b1;
      end
    end
  end

  a_r10_busy_nack: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxPos == 2'd0 && !rxByte[0] && busyIn) |=> (ackStrobe && !ackOk));
  a_r8_second_nack: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxPos == 2'd3) |=> (ackStrobe && !ackOk));
  a_r1_foreign_nack: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxPos == 2'd0 && rxByte[7:1] != DEV_ADDR) |=> !ackOk);
  a_r11_one_byte: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !evStart) |=> !rdStrobe);
endmodule

// File: rtl/cfgLockData.sv
module cfgLockData
  import cfgLockPkg::*;
#(
  parameter int BUSY_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpIn,
  input  strobeT            strb,
  output logic              welOut,
  output logic              rwelOut,
  output logic              busyOut,
  output logic [BYTE_W-1:0] imageOut
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [BYTE_W-1:0] nvBits, nvNext;
  logic [CNT_W-1:0]  cnt;
  logic wel, rwel, busy;
  logic startCommit, doneCommit;

  assign startCommit = strb.commit && !wpIn && !busy;
  assign doneCommit  = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nvBits <= '0;
      nvNext <= '0;
      cnt    <= '0;
      wel    <= 1'b0;
      rwel   <= 1'b0;
      busy   <= 1'b0;
    end else begin
      if (strb.setWel)  wel  <= 1'b1;
      if (strb.setRwel) rwel <= 1'b1;
      if (startCommit) begin
        busy   <= 1'b1;
        cnt    <= CNT_LOAD;
        nvNext <= strb.data & NV_MASK;
      end else if (doneCommit) begin
        busy   <= 1'b0;
        nvBits <= nvNext;
        rwel   <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    imageOut           = nvBits & NV_MASK;
    imageOut[WEL_BIT]  = wel;
    imageOut[RWEL_BIT] = rwel;
  end
  assign welOut  = wel;
  assign rwelOut = rwel;
  assign busyOut = busy;

  a_r9_wp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && wpIn) |=> ($stable(nvBits) && !$rose(busy)));
  a_r5_rwel_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !rwel);
  a_r6_nv_only_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(nvBits) |-> $fell(busy));
  a_r3_latch_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setWel && !busy) |=> (wel && !busy));
endmodule

// File: rtl/cfgLockReg.sv
module cfgLockReg
  import cfgLockPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010010,
  parameter logic [7:0] REG_ADDR    = 8'hFF,
  parameter int         BUSY_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wpIn,
  input  logic       evStart,
  input  logic       evStop,
  input  logic       rxValid,
  input  logic [1:0] rxPos,
  input  logic [7:0] rxByte,
  input  logic       rdReq,
  output logic       ackStrobe,
  output logic       ackOk,
  output logic       rdStrobe,
  output logic [7:0] rdData,
  output logic [7:0] regImage,
  output logic       busy
);
  strobeT strb;
  logic wel, rwel;

  cfgLockCtrl #(.DEV_ADDR(DEV_ADDR), .REG_ADDR(REG_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .rxValid(rxValid), .rxPos(rxPos), .rxByte(rxByte), .rdReq(rdReq),
    .welIn(wel), .rwelIn(rwel), .busyIn(busy), .imageIn(regImage),
    .ackStrobe(ackStrobe), .ackOk(ackOk), .rdStrobe(rdStrobe),
    .rdData(rdData), .strb(strb)
  );

  cfgLockData #(.BUSY_CYCLES(BUSY_CYCLES)) uData (
    .clk(clk), .rstN(rstN), .wpIn(wpIn), .strb(strb),
    .welOut(wel), .rwelOut(rwel), .busyOut(busy), .imageOut(regImage)
  );
endmodule

// File: tb/tb_cfgLockReg.sv
module tb_cfgLockReg;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 20;

  logic clk = 0, rstN = 0, wpIn = 0, evStart = 0, evStop = 0;
  logic rxValid = 0, rdReq = 0;
  logic [1:0] rxPos = 0;
  logic [7:0] rxByte = 0;
  logic ackStrobe, ackOk, rdStrobe, busy;
  logic [7:0] rdData, regImage;

  int checks = 0, errors = 0;
  int expQ[$];
  string tagQ[$];
  bit isRdQ[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgLockReg #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .wpIn(wpIn), .evStart(evStart), .evStop(evStop),
    .rxValid(rxValid), .rxPos(rxPos), .rxByte(rxByte), .rdReq(rdReq),
    .ackStrobe(ackStrobe), .ackOk(ackOk), .rdStrobe(rdStrobe),
    .rdData(rdData), .regImage(regImage), .busy(busy)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (rstN && (ackStrobe || rdStrobe)) begin
      if (expQ.size() == 0) begin
        check("unexpected strobe", 1, 0);
      end else begin
        automatic int e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        automatic bit r = isRdQ.pop_front();
        if (r) check({t, " rdStrobe"}, rdStrobe, 1);
        if (r) check({t, " read"}, rdData, e);
        else   check({t, " ack"}, ackOk, e);
      end
    end
  end

  task automatic pulseStart();
    @(negedge clk) evStart = 1;
    @(negedge clk) evStart = 0;
  endtask
  task automatic pulseStop();
    @(negedge clk) evStop = 1;
    @(negedge clk) evStop = 0;
  endtask
  task automatic sendByte(int pos, logic [7:0] b, bit expAck, string tag);
    @(negedge clk);
    expQ.push_back(expAck); tagQ.push_back(tag); isRdQ.push_back(0);
    rxValid = 1; rxPos = 2'(pos); rxByte = b;
    @(negedge clk) rxValid = 0;
  endtask
  task automatic writeReg(logic [7:0] d, string tag);
    pulseStart();
    sendByte(0, 8'hA4, 1, tag);
    sendByte(1, 8'hFF, 1, tag);
    sendByte(2, d, 1, tag);
    pulseStop();
  endtask
  task automatic readReg(logic [7:0] exp, string tag);
    pulseStart();
    sendByte(0, 8'hA4, !busy, tag);
    if (!busy) sendByte(1, 8'hFF, 1, tag);
    pulseStart();
    sendByte(0, 8'hA5, 1, tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag); isRdQ.push_back(1);
    rdReq = 1;
    @(negedge clk) rdReq = 0;
    @(negedge clk) rdReq = 1;           // extra request: no byte expected
    @(negedge clk) begin rdReq = 0; check({tag, " R11 extra read"}, rdStrobe, 0); end
    pulseStop();
  endtask
  task automatic waitIdle();
    for (int i = 0; i < 4 * BUSY && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      check("watchdog", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R12 reset image", regImage, 8'h00);
    check("R12 reset busy", busy, 0);

    writeReg(8'h06, "R4 06 without WEL");
    check("R4 image", regImage, 8'h00);

    writeReg(8'h02, "R3 set WEL");
    check("R3 image", regImage, 8'h02);
    check("R3 no busy", busy, 0);

    writeReg(8'h06, "R4 set both");
    check("R4 image both", regImage, 8'h06);

    readReg(8'h06, "R11 read armed");

    writeReg(8'hF9, "R5 commit");
    check("R5 busy", busy, 1);
    pulseStart();
    sendByte(0, 8'hA4, 0, "R10 write while busy");
    pulseStop();
    readReg(8'h06, "R10 read while busy");
    waitIdle();
    check("R5 image after commit", regImage, 8'hFB);

    writeReg(8'h02, "R7 step1");
    writeReg(8'h06, "R6 arm");
    writeReg(8'hFD, "R6 bit2 set");
    check("R6 no busy", busy, 0);
    check("R6 image", regImage, 8'hFF);

    writeReg(8'h02, "R7 final 02");
    check("R7 busy", busy, 1);
    waitIdle();
    check("R7 cleared", regImage, 8'h02);

    writeReg(8'h06, "R9 arm");
    wpIn = 1;
    writeReg(8'hFB, "R9 protected write");
    check("R9 no busy", busy, 0);
    check("R9 image", regImage, 8'h06);
    wpIn = 0;

    pulseStart();
    sendByte(0, 8'hA4, 1, "R2 dev");
    sendByte(1, 8'h10, 0, "R2 bad reg addr");
    sendByte(2, 8'h81, 0, "R2 data after bad addr");
    pulseStop();
    check("R2 image", regImage, 8'h06);

    pulseStart();
    sendByte(0, 8'hA4, 1, "R8 dev");
    sendByte(1, 8'hFF, 1, "R8 reg");
    sendByte(2, 8'h81, 1, "R8 first data");
    sendByte(3, 8'h00, 0, "R8 second data");
    pulseStop();
    check("R8 no busy", busy, 0);
    check("R8 image", regImage, 8'h06);

    pulseStart();
    sendByte(0, 8'hA0, 0, "R1 foreign addr");
    sendByte(0, 8'h24, 0, "R1 foreign addr 2");
    pulseStop();

    writeReg(8'h81, "R5 bit order");
    waitIdle();
    check("R5 bit order image", regImage, 8'h83);
    readReg(8'h83, "R11 read final");

    repeat (3) @(negedge clk);
    check("queue drained", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule